// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches the pins of one GPIO bank, made of several ports of eight pins each, and raises a single bank interrupt when an enabled pin has a pending event. Every pin has its own sense setting. The setting picks level or edge detection. It also picks the active level or active edge, or it selects both edges. Pin inputs are first synchronised to the block clock. Edges are then found against a history register that follows each pin at all times.

Pending status is kept per pin and is shown as one byte per port. In edge mode the status stays latched until the clear strobe removes it. In level mode the status follows the active level. The per-pin enable decides whether a pending pin drives the bank interrupt, and it has no effect on the status bytes. The register file that holds the sense, enable and clear values lives outside this block and feeds it directly.

Top module: `gpio_bank_irq`

## Requirements
- R1: Each port has a sense word of 3×8 bits. For pin p, bit p is polarity, bit p+8 selects edge mode and bit p+16 selects both edges. The codes are: rising = edge+polarity, falling = edge only, both = both+edge, level high = polarity only, level low = all zero.
- R2: In edge mode a matching edge sets the pin's pending bit. Rising mode reacts to 0→1 only, falling mode to 1→0 only, and both-edges mode to either.
- R3: In level mode the pending bit equals the active level (high when polarity=1, low when polarity=0). It reappears right after a clear while that level persists.
- R4: An edge-mode pending bit stays set, even after the pin returns, until it is cleared.
- R5: When clear_stb_i is high, pending bits whose clear_mask_i bit is 1 are cleared. Other bits are untouched, and clear_mask_i has no effect while the strobe is low.
- R6: An edge that is detected in the same cycle as a clear of that pin leaves the pin pending.
- R7: bank_irq_o is high when any pin of any port has both its pending bit and its enable_i bit set. status_o shows pending bits whatever the enable.
- R8: A pin change is seen in status_o after the third rising clock edge: two synchroniser stages, then the pending register.
- R9: Changing a pin's sense setting while the pin is held steady never creates a pending edge.
- R10: During and right after reset, status_o is all zero and bank_irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PORTS*PINS_PER_PORT | Raw pin levels, port k at bits [8k+7:8k] |
| sense_cfg_i | input | NUM_PORTS*3*PINS_PER_PORT | Sense words, port k at bits [24k+23:24k] |
| enable_i | input | NUM_PORTS*PINS_PER_PORT | Per-pin interrupt enable |
| clear_mask_i | input | NUM_PORTS*PINS_PER_PORT | Pins that the clear strobe acts on |
| clear_stb_i | input | 1 | Write-one clear strobe |
| status_o | output | NUM_PORTS*PINS_PER_PORT | Pending bits, one byte per port |
| bank_irq_o | output | 1 | Combined bank interrupt |

## Verification
The bench uses the default build: four ports of eight pins and two synchroniser stages. That makes all 32 status bits and the port-to-bank merge visible, including a pending bit in the last port alone. With two stages the three-edge latency is short enough to check cycle by cycle, and the bench can place a clear exactly on the cycle in which an edge is detected.

// File: rtl/gpio_bank_irq_pkg.sv
package gpio_bank_irq_pkg;

  typedef struct packed {
    logic both;
    logic edge_sel;
    logic pol;
  } sense_t;

  // Edge seen on a pin for a given sense setting
  function automatic logic edge_hit_f(input sense_t s, input logic cur, input logic prev);
    logic rise;
    logic fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (!s.edge_sel)  return 1'b0;
    if (s.both)       return rise | fall;
    return s.pol ? rise : fall;
  endfunction

  // Active level for a level-sensed pin
  function automatic logic level_act_f(input sense_t s, input logic cur);
    return s.pol ? cur : ~cur;
  endfunction

  // Next pending state
  function automatic logic pend_next_f(input sense_t s, input logic pend,
                                       input logic clr, input logic hit, input logic act);
    if (s.edge_sel) return (pend & ~clr) | hit;
    return act;
  endfunction

endpackage

// File: rtl/gpio_bank_irq_sync.sv
module gpio_bank_irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_irq_port.sv
module gpio_bank_irq_port
  import gpio_bank_irq_pkg::*;
#(
  parameter int PW = 8,
  localparam int SW = 3 * PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] sync_i,
  input  logic [SW-1:0] sense_word_i,
  input  logic [PW-1:0] clr_sel_i,
  output logic [PW-1:0] pend_o,
  output logic [PW-1:0] hist_o,
  output logic [PW-1:0] hit_o,
  output logic [PW-1:0] level_act_o,
  output logic [PW-1:0] edge_mode_o
);

  logic [PW-1:0] hist_q;
  logic [PW-1:0] pend_q;

  for (genvar p = 0; p < PW; p++) begin : g_pin
    sense_t sense;
    logic   pend_d;

    assign sense.pol      = sense_word_i[p];
    assign sense.edge_sel = sense_word_i[PW + p];
    assign sense.both     = sense_word_i[2*PW + p];

    assign hit_o[p]       = edge_hit_f(sense, sync_i[p], hist_q[p]);
    assign level_act_o[p] = level_act_f(sense, sync_i[p]);
    assign edge_mode_o[p] = sense.edge_sel;
    assign pend_d = pend_next_f(sense, pend_q[p], clr_sel_i[p], hit_o[p], level_act_o[p]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q[p] <= 1'b0;
        pend_q[p] <= 1'b0;
      end else begin
        hist_q[p] <= sync_i[p];
        pend_q[p] <= pend_d;
      end
    end
  end

  assign pend_o = pend_q;
  assign hist_o = hist_q;

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int NUM_PORTS     = 4,
  parameter int PINS_PER_PORT = 8,
  parameter int SYNC_STAGES   = 2,
  localparam int LINES = NUM_PORTS * PINS_PER_PORT,
  localparam int SW    = 3 * PINS_PER_PORT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LINES-1:0]        pin_i,
  input  logic [NUM_PORTS*SW-1:0] sense_cfg_i,
  input  logic [LINES-1:0]        enable_i,
  input  logic [LINES-1:0]        clear_mask_i,
  input  logic                    clear_stb_i,
  output logic [LINES-1:0]        status_o,
  output logic                    bank_irq_o
);

  logic [LINES-1:0] sync_q;
  logic [LINES-1:0] hist_q;
  logic [LINES-1:0] edge_hit;
  logic [LINES-1:0] level_act;
  logic [LINES-1:0] edge_mode;
  logic [LINES-1:0] clr_sel;
  logic [LINES-1:0] pend_q;

  assign clr_sel = clear_mask_i & {LINES{clear_stb_i}};

  gpio_bank_irq_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(sync_q)
  );

  for (genvar k = 0; k < NUM_PORTS; k++) begin : g_port
    localparam int LO = k * PINS_PER_PORT;
    gpio_bank_irq_port #(.PW(PINS_PER_PORT)) u_port (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_i      (sync_q[LO +: PINS_PER_PORT]),
      .sense_word_i(sense_cfg_i[k*SW +: SW]),
      .clr_sel_i   (clr_sel[LO +: PINS_PER_PORT]),
      .pend_o      (pend_q[LO +: PINS_PER_PORT]),
      .hist_o      (hist_q[LO +: PINS_PER_PORT]),
      .hit_o       (edge_hit[LO +: PINS_PER_PORT]),
      .level_act_o (level_act[LO +: PINS_PER_PORT]),
      .edge_mode_o (edge_mode[LO +: PINS_PER_PORT])
    );
  end

  assign status_o   = pend_q;
  assign bank_irq_o = |(pend_q & enable_i);

endmodule

// File: rtl/gpio_bank_irq_checker.sv
module gpio_bank_irq_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] enable_i,
  input logic [W-1:0] status_o,
  input logic         bank_irq_o,
  input logic [W-1:0] sync_q,
  input logic [W-1:0] hist_q,
  input logic [W-1:0] edge_hit,
  input logic [W-1:0] edge_mode,
  input logic [W-1:0] level_act,
  input logic [W-1:0] clr_sel
);

  p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bank_irq_o |-> ((status_o & enable_i) != '0));

  p_hist_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hist_q == $past(sync_q)));

  p_hit_pends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_hit) & ~status_o) == '0));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(clr_sel & edge_mode & ~edge_hit) & status_o) == '0));

  p_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status_o & edge_mode & ~clr_sel) & ~status_o) == '0));

  p_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((status_o ^ $past(level_act)) & ~$past(edge_mode)) == '0));

endmodule

bind gpio_bank_irq gpio_bank_irq_checker #(.W(NUM_PORTS * PINS_PER_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .status_o(status_o),
  .bank_irq_o(bank_irq_o), .sync_q(sync_q), .hist_q(hist_q), .edge_hit(edge_hit),
  .edge_mode(edge_mode), .level_act(level_act), .clr_sel(clr_sel)
);

// File: tb/gpio_bank_irq_bench.sv
module gpio_bank_irq_bench;

  localparam int NP = 4;
  localparam int PW = 8;
  localparam int LN = NP * PW;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [LN-1:0]   pin = '0;
  logic [3*LN-1:0] cfg;
  logic [LN-1:0]   en = '1;
  logic [LN-1:0]   cmask = '0;
  logic            cstb = 1'b0;
  logic [LN-1:0]   status;
  logic            irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_bank_irq u_gpio_bank_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .sense_cfg_i(cfg), .enable_i(en),
    .clear_mask_i(cmask), .clear_stb_i(cstb), .status_o(status), .bank_irq_o(irq)
  );

  // {port[1:0], pin[2:0], sense{both,edge,pol}, start, end, expect}
  localparam logic [10:0] VEC [11] = '{
    {2'd0, 3'd0, 3'b011, 1'b0, 1'b1, 1'b1},
    {2'd0, 3'd5, 3'b011, 1'b1, 1'b0, 1'b0},
    {2'd1, 3'd2, 3'b010, 1'b1, 1'b0, 1'b1},
    {2'd1, 3'd7, 3'b010, 1'b0, 1'b1, 1'b0},
    {2'd2, 3'd3, 3'b110, 1'b0, 1'b1, 1'b1},
    {2'd2, 3'd4, 3'b110, 1'b1, 1'b0, 1'b1},
    {2'd3, 3'd1, 3'b001, 1'b1, 1'b1, 1'b1},
    {2'd3, 3'd6, 3'b001, 1'b0, 1'b0, 1'b0},
    {2'd0, 3'd7, 3'b000, 1'b0, 1'b0, 1'b1},
    {2'd1, 3'd0, 3'b000, 1'b1, 1'b1, 1'b0},
    {2'd3, 3'd0, 3'b011, 1'b1, 1'b1, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [LN-1:0] act, input logic [LN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // level-high everywhere: idle pins at 0 never pend
  function automatic logic [3*LN-1:0] cfg_default();
    logic [3*LN-1:0] c = '0;
    for (int k = 0; k < NP; k++) c[k*3*PW +: PW] = '1;
    return c;
  endfunction

  task automatic set_sense(input int port, input int p, input logic [2:0] s);
    cfg[port*3*PW + p]        = s[0];
    cfg[port*3*PW + PW + p]   = s[1];
    cfg[port*3*PW + 2*PW + p] = s[2];
  endtask

  task automatic clear_all();
    cmask = '1; cstb = 1'b1; tick(1); cstb = 1'b0; cmask = '0;
  endtask

  task automatic idle();
    cfg = cfg_default(); pin = '0; en = '1; tick(6); clear_all(); tick(2);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cfg = cfg_default();
    tick(3);
    check("R10 status in reset", status, '0);
    check("R10 irq in reset", {31'd0, irq}, '0);
    rst_n = 1'b1;
    tick(1);
    check("R10 status after reset", status, '0);
    check("R10 irq after reset", {31'd0, irq}, '0);
    tick(4);

    // R1 R2 R3 table
    for (int i = 0; i < 11; i++) begin
      int idx;
      logic [LN-1:0] expv;
      idx = int'(VEC[i][10:9]) * PW + int'(VEC[i][8:6]);
      set_sense(int'(VEC[i][10:9]), int'(VEC[i][8:6]), VEC[i][5:3]);
      pin[idx] = VEC[i][2];
      tick(6);
      clear_all();
      pin[idx] = VEC[i][1];
      tick(5);
      expv = '0; expv[idx] = VEC[i][0];
      check($sformatf("R1 R2 R3 vector %0d status", i), status, expv);
      check($sformatf("R1 vector %0d irq", i), {31'd0, irq}, {31'd0, VEC[i][0]});
      idle();
    end

    // R8 latency: rising on port0 pin0
    set_sense(0, 0, 3'b011); tick(2);
    pin[0] = 1'b1;
    tick(2);
    check("R8 not yet after two edges", status, '0);
    tick(1);
    check("R8 seen after third edge", status, 32'h1);
    // R4 stays latched after pin drops
    pin[0] = 1'b0; tick(6);
    check("R4 latched after pin returns", status, 32'h1);
    // R5 mask without strobe
    cmask = '1; tick(2); cmask = '0;
    check("R5 mask without strobe ignored", status, 32'h1);
    clear_all(); tick(1);
    check("R4 removed by clear", status, '0);
    idle();

    // R6 edge coinciding with clear, both-edges on port0 pin0
    set_sense(0, 0, 3'b110); tick(2);
    pin[0] = 1'b1; tick(5);
    check("R6 first edge pending", status, 32'h1);
    pin[0] = 1'b0; tick(2);
    cmask = 32'h1; cstb = 1'b1; tick(1); cstb = 1'b0; cmask = '0;
    check("R6 edge with clear stays pending", status, 32'h1);
    clear_all(); tick(1);
    check("R6 plain clear empties", status, '0);
    idle();

    // R5 selective clear on port2 pins 1 and 2
    set_sense(2, 1, 3'b011); set_sense(2, 2, 3'b011); tick(2);
    pin[17] = 1'b1; pin[18] = 1'b1; tick(5);
    check("R5 two pending", status, 32'h0006_0000);
    cmask = 32'h0002_0000; cstb = 1'b1; tick(1); cstb = 1'b0; cmask = '0;
    check("R5 only selected cleared", status, 32'h0004_0000);
    idle();

    // R7 enable gating and bank merge from last port
    set_sense(3, 7, 3'b011); tick(2);
    en = '0; pin[31] = 1'b1; tick(5);
    check("R7 status without enable", status, 32'h8000_0000);
    check("R7 irq gated off", {31'd0, irq}, '0);
    en[31] = 1'b1; tick(1);
    check("R7 irq from last port", {31'd0, irq}, 32'h1);
    idle();

    // R3 level returns after clear
    pin[9] = 1'b1; tick(5);
    check("R3 level high pending", status, 32'h0000_0200);
    clear_all();
    check("R3 level back after clear", status, 32'h0000_0200);
    pin[9] = 1'b0; tick(4);
    check("R3 level drop follows", status, '0);
    idle();

    // R9 sense change with steady pin
    set_sense(1, 4, 3'b000); pin[12] = 1'b1; tick(6);
    check("R9 level low with pin high", status, '0);
    set_sense(1, 4, 3'b011); tick(5);
    check("R9 switch to rising no edge", status, '0);
    set_sense(1, 4, 3'b110); tick(5);
    check("R9 switch to both no edge", status, '0);
    set_sense(1, 4, 3'b010); tick(5);
    check("R9 switch to falling no edge", status, '0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule